// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block holds the working state of one DMA channel that moves data in two bus cycles per unit: a read at the source address, then a write at the destination address. A configuration strobe loads a source pointer, a destination pointer, a transfer count and a block size. Each pointer is loaded into a working register and a reload copy. An external arbiter then grants bus steps one at a time. The engine presents the address for the current phase and advances its state on every granted step.

The block size sets how many units move per request. After the write of the last unit in a block, the transfer count drops by one. When the count runs out, the channel either stops or, with reload on, restores the count and any pointer whose reload flag is set, and keeps running. A one-cycle end pulse, intended for channels that drive an external pin, marks the final write of the whole transfer.

Top module: `dma_chan_engine`

## Requirements
- R1: While reset is applied and after it, until the first load, `busy`, `bus_wr`, `blk_end`, `xfer_end` and `eop` are low, and `bus_addr` and `tcount` are zero.
- R2: A cycle with `cfg_load` high captures both pointers, the count, the block size, the modes, the width and the reload flags. In the next cycle `busy` is high, the engine is in the read phase, `bus_addr` equals `cfg_src` and `tcount` equals `cfg_tcount`.
- R3: In the read phase `bus_addr` shows the source pointer and `bus_wr` is low. In the write phase `bus_addr` shows the destination pointer and `bus_wr` is high. The phase toggles only on a cycle with `step_grant` high while busy.
- R4: After each granted write step, each pointer moves according to its own mode. Mode 0 increments, mode 1 decrements, and modes 2 and 3 leave the pointer fixed. The step is set by `cfg_width`: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Pointer arithmetic wraps modulo 2^32.
- R5: `blk_end` is high, combinationally with the granted write step, when that step completes a block of N units. N equals `cfg_blk`, and a value of 0 means 16.
- R6: `tcount` decreases by one after each completed block and holds at all other times.
- R7: With `cfg_reload` low, `xfer_end` is high on the granted write step that completes a block while `tcount` is 1. `busy` is low from the next cycle, and `tcount` reads 0.
- R8: With `cfg_reload` high, the same step restores `tcount` to the loaded count and keeps `busy` high. Each pointer whose reload flag (`cfg_src_rl`, `cfg_dst_rl`) was set returns to its loaded value. A pointer whose flag was clear takes its normal advanced value.
- R9: `eop` pulses for exactly the cycles in which `xfer_end` is high, when the channel has an end pin (`HAS_EOP`=1).
- R10: `step_grant` while not busy has no effect on any output.
- R11: A load while busy abandons the running transfer and restarts from the new configuration in the read phase with the first unit of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load configuration and start the channel |
| cfg_src | input | 32 | Source start address |
| cfg_dst | input | 32 | Destination start address |
| cfg_tcount | input | 16 | Number of blocks in the transfer |
| cfg_blk | input | 4 | Units per block (0 means 16) |
| cfg_src_mode | input | 2 | Source pointer mode (0 inc, 1 dec, 2/3 fixed) |
| cfg_dst_mode | input | 2 | Destination pointer mode (0 inc, 1 dec, 2/3 fixed) |
| cfg_width | input | 2 | Unit width (0: 1 B, 1: 2 B, 2/3: 4 B) |
| cfg_reload | input | 1 | Restart the count when it runs out |
| cfg_src_rl | input | 1 | Restore the source pointer on reload |
| cfg_dst_rl | input | 1 | Restore the destination pointer on reload |
| step_grant | input | 1 | Bus step granted this cycle |
| bus_addr | output | 32 | Address for the current phase |
| bus_wr | output | 1 | High in the write phase |
| busy | output | 1 | Channel enabled |
| tcount | output | 16 | Remaining block count |
| blk_end | output | 1 | Granted write step completes a block |
| xfer_end | output | 1 | Granted write step completes the transfer |
| eop | output | 1 | End pulse for the external pin |

## Verification
The engine is driven with several kinds of grant stream. A continuous grant stream checks that phase and pointer movement line up cycle for cycle. Sparse random grants show whether any state moves without a grant. Grants while idle show whether a stale phase or pointer leaks out. The configurations cover each pointer mode and width, a block size of 16 encoded as zero, a single-block transfer, a pointer wrapping past the top of the address space, and reload with only one pointer restored, which separates restore from advance. A load issued in the middle of a block checks that the unit and phase counters restart.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [1:0] {
    AM_INC  = 2'd0,
    AM_DEC  = 2'd1,
    AM_FIX  = 2'd2,
    AM_FIXB = 2'd3
  } addr_mode_e;

  typedef enum logic {
    PH_RD = 1'b0,
    PH_WR = 1'b1
  } phase_e;

  // Bytes moved per unit for a width code.
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    width_bytes = 3'd1;
      2'd1:    width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
  import dma_eng_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_mode,
  input  logic          ld_rl_en,
  input  logic          adv,
  input  logic [2:0]    step,
  input  logic          restore,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] rl_q,   rl_d;
  addr_mode_e    mode_q, mode_d;
  logic          rl_en_q, rl_en_d;
  logic [AW-1:0] stepped;
  logic [AW-1:0] step_ext;

  assign step_ext = AW'(step);

  always_comb begin
    case (mode_q)
      AM_INC:  stepped = addr_q + step_ext;
      AM_DEC:  stepped = addr_q - step_ext;
      default: stepped = addr_q;
    endcase
  end

  always_comb begin
    addr_d  = addr_q;
    rl_d    = rl_q;
    mode_d  = mode_q;
    rl_en_d = rl_en_q;
    if (ld) begin
      addr_d  = ld_addr;
      rl_d    = ld_addr;
      mode_d  = addr_mode_e'(ld_mode);
      rl_en_d = ld_rl_en;
    end else if (restore && rl_en_q) begin
      addr_d = rl_q;
    end else if (adv) begin
      addr_d = stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rl_q    <= '0;
      mode_q  <= AM_INC;
      rl_en_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      rl_q    <= rl_d;
      mode_q  <= mode_d;
      rl_en_q <= rl_en_d;
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/dma_blk_count.sv
module dma_blk_count #(
  parameter int TCW = 16,
  parameter int BCW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld,
  input  logic [TCW-1:0] ld_tc,
  input  logic [BCW-1:0] ld_blk,
  input  logic           adv,
  input  logic           restore,
  output logic [TCW-1:0] tc_o,
  output logic           blk_last,
  output logic           tc_last
);

  localparam int UW = BCW + 1;
  localparam logic [UW-1:0] FULL_BLK = UW'(1) << BCW;

  logic [TCW-1:0] tc_q, tc_d, tc_rl_q, tc_rl_d;
  logic [BCW-1:0] blk_q, blk_d, unit_q, unit_d;
  logic [UW-1:0]  blk_eff, unit_next;

  assign blk_eff   = (blk_q == '0) ? FULL_BLK : {1'b0, blk_q};
  assign unit_next = {1'b0, unit_q} + UW'(1);
  assign blk_last  = (unit_next == blk_eff);
  assign tc_last   = (tc_q == TCW'(1));

  always_comb begin
    tc_d    = tc_q;
    tc_rl_d = tc_rl_q;
    blk_d   = blk_q;
    unit_d  = unit_q;
    if (ld) begin
      tc_d    = ld_tc;
      tc_rl_d = ld_tc;
      blk_d   = ld_blk;
      unit_d  = '0;
    end else if (adv) begin
      if (blk_last) begin
        unit_d = '0;
        if (tc_last && restore) tc_d = tc_rl_q;
        else                    tc_d = tc_q - TCW'(1);
      end else begin
        unit_d = unit_next[BCW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q    <= '0;
      tc_rl_q <= '0;
      blk_q   <= '0;
      unit_q  <= '0;
    end else begin
      tc_q    <= tc_d;
      tc_rl_q <= tc_rl_d;
      blk_q   <= blk_d;
      unit_q  <= unit_d;
    end
  end

  assign tc_o = tc_q;

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_eng_pkg::*;
#(
  parameter int AW      = 32,
  parameter int TCW     = 16,
  parameter int BCW     = 4,
  parameter bit HAS_EOP = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [TCW-1:0] cfg_tcount,
  input  logic [BCW-1:0] cfg_blk,
  input  logic [1:0]     cfg_src_mode,
  input  logic [1:0]     cfg_dst_mode,
  input  logic [1:0]     cfg_width,
  input  logic           cfg_reload,
  input  logic           cfg_src_rl,
  input  logic           cfg_dst_rl,
  input  logic           step_grant,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_wr,
  output logic           busy,
  output logic [TCW-1:0] tcount,
  output logic           blk_end,
  output logic           xfer_end,
  output logic           eop
);

  localparam int NPTR = 2;  // index 0 source, 1 destination

  logic rst_n_int;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  logic       busy_q, busy_d;
  phase_e     phase_q, phase_d;
  logic [1:0] width_q, width_d;
  logic       reload_q, reload_d;

  logic       wr_step, blk_last, tc_last, done_step, restore;
  logic [2:0] step_b;

  assign wr_step   = busy_q && step_grant && (phase_q == PH_WR);
  assign done_step = wr_step && blk_last && tc_last;
  assign restore   = done_step && reload_q;
  assign step_b    = width_bytes(width_q);

  // Pointer pair
  logic [AW-1:0] ptr_ld   [NPTR];
  logic [1:0]    ptr_mode [NPTR];
  logic          ptr_rl   [NPTR];
  logic [AW-1:0] ptr_q    [NPTR];

  assign ptr_ld[0]   = cfg_src;
  assign ptr_ld[1]   = cfg_dst;
  assign ptr_mode[0] = cfg_src_mode;
  assign ptr_mode[1] = cfg_dst_mode;
  assign ptr_rl[0]   = cfg_src_rl;
  assign ptr_rl[1]   = cfg_dst_rl;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_addr_reg #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .ld       (cfg_load),
      .ld_addr  (ptr_ld[g]),
      .ld_mode  (ptr_mode[g]),
      .ld_rl_en (ptr_rl[g]),
      .adv      (wr_step),
      .step     (step_b),
      .restore  (restore),
      .addr_o   (ptr_q[g])
    );
  end

  dma_blk_count #(.TCW(TCW), .BCW(BCW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .ld       (cfg_load),
    .ld_tc    (cfg_tcount),
    .ld_blk   (cfg_blk),
    .adv      (wr_step),
    .restore  (reload_q),
    .tc_o     (tcount),
    .blk_last (blk_last),
    .tc_last  (tc_last)
  );

  always_comb begin
    busy_d   = busy_q;
    phase_d  = phase_q;
    width_d  = width_q;
    reload_d = reload_q;
    if (cfg_load) begin
      busy_d   = 1'b1;
      phase_d  = PH_RD;
      width_d  = cfg_width;
      reload_d = cfg_reload;
    end else if (busy_q && step_grant) begin
      phase_d = (phase_q == PH_RD) ? PH_WR : PH_RD;
      if (done_step && !reload_q) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      busy_q   <= 1'b0;
      phase_q  <= PH_RD;
      width_q  <= 2'd0;
      reload_q <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      phase_q  <= phase_d;
      width_q  <= width_d;
      reload_q <= reload_d;
    end
  end

  assign busy     = busy_q;
  assign bus_wr   = busy_q && (phase_q == PH_WR);
  assign bus_addr = (phase_q == PH_WR) ? ptr_q[1] : ptr_q[0];
  assign blk_end  = wr_step && blk_last;
  assign xfer_end = done_step;

  if (HAS_EOP) begin : g_eop
    assign eop = done_step;
  end else begin : g_no_eop
    assign eop = 1'b0;
  end

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int AW  = 32,
  parameter int TCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_load,
  input logic           step_grant,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_wr,
  input logic           busy,
  input logic [TCW-1:0] tcount,
  input logic           blk_end,
  input logic           xfer_end,
  input logic           eop
);

  assert_wr_needs_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> busy);

  assert_hold_without_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_grant && !cfg_load) |=> ($stable(bus_addr) && $stable(tcount) && $stable(bus_wr)));

  assert_blk_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |-> (bus_wr && step_grant));

  assert_tc_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && !xfer_end && !cfg_load) |=> (tcount == $past(tcount) - TCW'(1)));

  assert_end_in_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> (blk_end && tcount == TCW'(1)));

  assert_stop_only_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(xfer_end));

  assert_eop_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> (bus_wr && xfer_end));

  assert_idle_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_load) |=> (!busy && $stable(bus_addr) && $stable(tcount)));

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .TCW(TCW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .step_grant (step_grant),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .busy       (busy),
  .tcount     (tcount),
  .blk_end    (blk_end),
  .xfer_end   (xfer_end),
  .eop        (eop)
);

// File: tb/dma_chan_engine_test.sv
module dma_chan_engine_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [31:0] cfg_src, cfg_dst;
  logic [15:0] cfg_tcount;
  logic [3:0]  cfg_blk;
  logic [1:0]  cfg_src_mode, cfg_dst_mode, cfg_width;
  logic        cfg_reload, cfg_src_rl, cfg_dst_rl;
  logic        step_grant;
  logic [31:0] bus_addr;
  logic        bus_wr, busy, blk_end, xfer_end, eop;
  logic [15:0] tcount;

  always #4 clk = ~clk;  // 125 MHz

  dma_chan_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_tcount(cfg_tcount), .cfg_blk(cfg_blk), .cfg_src_mode(cfg_src_mode),
    .cfg_dst_mode(cfg_dst_mode), .cfg_width(cfg_width), .cfg_reload(cfg_reload),
    .cfg_src_rl(cfg_src_rl), .cfg_dst_rl(cfg_dst_rl), .step_grant(step_grant),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .busy(busy), .tcount(tcount),
    .blk_end(blk_end), .xfer_end(xfer_end), .eop(eop)
  );

  int    n_run = 0, n_fail = 0, cycles = 0;
  string phase_tag = "R1";
  bit    cmp_on = 1'b0;

  // Behavioural reference state
  logic [31:0] m_src, m_dst, m_src0, m_dst0;
  logic [15:0] m_tc, m_tc0;
  int          m_blk, m_unit, m_w;
  int          m_smode, m_dmode;
  bit          m_busy, m_wr, m_rel, m_srl, m_drl;

  function automatic logic [31:0] move(input logic [31:0] a, input int mode, input int w);
    int b;
    b = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    if (mode == 0) return a + 32'(b);
    if (mode == 1) return a - 32'(b);
    return a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_src0 = 0; m_dst0 = 0; m_tc = 0; m_tc0 = 0;
      m_blk = 0; m_unit = 0; m_w = 0; m_smode = 0; m_dmode = 0;
      m_busy = 0; m_wr = 0; m_rel = 0; m_srl = 0; m_drl = 0;
    end else if (cfg_load) begin
      m_src = cfg_src; m_src0 = cfg_src; m_dst = cfg_dst; m_dst0 = cfg_dst;
      m_tc = cfg_tcount; m_tc0 = cfg_tcount;
      m_blk = (cfg_blk == 0) ? 16 : int'(cfg_blk);
      m_unit = 0; m_w = int'(cfg_width);
      m_smode = int'(cfg_src_mode); m_dmode = int'(cfg_dst_mode);
      m_rel = cfg_reload; m_srl = cfg_src_rl; m_drl = cfg_dst_rl;
      m_busy = 1; m_wr = 0;
    end else if (m_busy && step_grant) begin
      if (!m_wr) m_wr = 1;
      else begin
        m_wr = 0;
        m_src = move(m_src, m_smode, m_w);
        m_dst = move(m_dst, m_dmode, m_w);
        m_unit++;
        if (m_unit == m_blk) begin
          m_unit = 0;
          if (m_tc == 1 && m_rel) begin
            m_tc = m_tc0;
            if (m_srl) m_src = m_src0;
            if (m_drl) m_dst = m_dst0;
          end else begin
            if (m_tc == 1) m_busy = 0;
            m_tc = m_tc - 16'd1;
          end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s [%s] actual=%0h expected=%0h at cycle %0d", req, what, phase_tag, act, exp, cycles);
    end
  endtask

  // Compare every cycle, 2 ns after inputs change on the falling edge
  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      bit e_blk, e_end;
      #2;
      e_blk = m_busy && m_wr && step_grant && (m_unit + 1 == m_blk);
      e_end = e_blk && (m_tc == 1);
      chk("R3/R4", "bus_addr", bus_addr, m_wr ? m_dst : m_src);
      chk("R3", "bus_wr", bus_wr, m_busy && m_wr);
      chk("R7/R8", "busy", busy, m_busy);
      chk("R6", "tcount", tcount, m_tc);
      chk("R5", "blk_end", blk_end, e_blk);
      chk("R7", "xfer_end", xfer_end, e_end);
      chk("R9", "eop", eop, e_end);
    end
  end

  task automatic idle_in();
    cfg_load = 0; step_grant = 0; cfg_src = 0; cfg_dst = 0; cfg_tcount = 0; cfg_blk = 0;
    cfg_src_mode = 0; cfg_dst_mode = 0; cfg_width = 0; cfg_reload = 0; cfg_src_rl = 0; cfg_dst_rl = 0;
  endtask

  task automatic load(input logic [31:0] s, input logic [31:0] d, input logic [15:0] tc,
                      input logic [3:0] b, input logic [1:0] sm, input logic [1:0] dm,
                      input logic [1:0] w, input bit rel, input bit srl, input bit drl);
    @(negedge clk);
    cfg_load = 1; cfg_src = s; cfg_dst = d; cfg_tcount = tc; cfg_blk = b;
    cfg_src_mode = sm; cfg_dst_mode = dm; cfg_width = w;
    cfg_reload = rel; cfg_src_rl = srl; cfg_dst_rl = drl; step_grant = 0;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic run(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      step_grant = (($urandom % 100) < pct);
      @(negedge clk);
    end
    step_grant = 0;
  endtask

  initial begin
    idle_in();
    rst_n = 0;
    #1 cmp_on = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    phase_tag = "R10";
    run(12, 100);

    phase_tag = "R2";
    load(32'h0000_1000, 32'h0000_2000, 16'd3, 4'd2, 2'd0, 2'd0, 2'd2, 0, 0, 0);
    run(30, 100);

    phase_tag = "R5";
    load(32'h0000_3000, 32'h0000_4000, 16'd1, 4'd0, 2'd1, 2'd2, 2'd0, 0, 0, 0);
    run(120, 55);

    phase_tag = "R8";
    load(32'h0000_5000, 32'h0000_6000, 16'd2, 4'd3, 2'd0, 2'd1, 2'd1, 1, 1, 0);
    run(80, 70);

    phase_tag = "R11";
    step_grant = 1; @(negedge clk); step_grant = 0;
    load(32'h0000_7000, 32'h0000_8000, 16'd2, 4'd1, 2'd3, 2'd0, 2'd3, 1, 0, 1);
    run(40, 80);

    phase_tag = "R4";
    load(32'hFFFF_FFFC, 32'h0000_0002, 16'd2, 4'd3, 2'd0, 2'd1, 2'd2, 0, 0, 0);
    run(60, 100);

    phase_tag = "R10";
    run(10, 100);

    cmp_on = 0;
    #3;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_fail++;
    $display("FAIL watchdog expired (actual=hung expected=done)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule